// File: doc/BRIEF.md
# RF Transmit Power-State Sequencer

This block sequences the power domains of a sub-GHz transmitter front end that is keyed by one data pin. At rest it sits in a low-power state with every enable off. A rising edge on the data pin wakes it. It then enables the crystal oscillator for a fixed start-up interval. Next it enables the frequency synthesizer for a fixed tuning interval. Finally it enters the transmit state, where the data pin drives the power-amplifier enable directly.

The block shuts itself down without help. If the data pin stays low in transmit for longer than a selectable stop time, it returns to sleep. While a serial configuration session is running, pin edges are not allowed to wake it. A soft-reset pulse sends it straight back to sleep from any state.

All intervals are counted in system-clock cycles and set by parameters. The stop time is selected at run time in millisecond units, and one millisecond equals `CYC_PER_MS` clock cycles.

Top module: `rf_tx_seq`

## Requirements
- R1: While `rst_n` is low, `state` reads 0 (sleep) and `xo_en`, `synth_en` and `pa_en` are all 0.
- R2: `state` uses the codes 0 = sleep, 1 = oscillator start-up, 2 = tune and 3 = transmit. `xo_en` is 1 in every state except sleep. `synth_en` is 1 in tune and in transmit. A state change either steps to the next code or returns to sleep.
- R3: In sleep, with `cfg_mode` low, a 0-to-1 change on `tx_pin` passes through a two-flop synchronizer. The state reads 1 after the third rising clock edge that follows the pin change.
- R4: The oscillator start-up state lasts exactly `XO_CYCLES` clock cycles and is then followed by tune.
- R5: The tune state lasts exactly `TUNE_CYCLES` clock cycles and is then followed by transmit.
- R6: `pa_en` equals `tx_pin` delayed by two clock cycles while in transmit, and is 0 in every other state.
- R7: In transmit, once the synchronized pin has been sampled low on more than S consecutive clock edges, the block returns to sleep. S is the stop time in cycles. After the pin falls, the state stays at transmit for exactly S+2 sampled cycles.
- R8: `stop_sel[3]` picks the stop-time range. When it is 0, the stop time is (`stop_sel[2:0]`+2) ms, giving 2 to 9 ms. When it is 1, the stop time is (`stop_sel[2:0]`+2)×10 ms, giving 20 to 90 ms. One ms equals `CYC_PER_MS` cycles.
- R9: Any cycle in which the synchronized pin is high during transmit restarts the low-time count from zero.
- R10: While `cfg_mode` is high, rising edges on `tx_pin` leave the block in sleep.
- R11: A `soft_rst` pulse makes the state read sleep after the next clock edge, from any state. It takes priority over every other transition.
- R12: A pin that is already high when `cfg_mode` falls does not wake the block. Only a 0-to-1 transition seen while `cfg_mode` is low does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_pin | input | 1 | Asynchronous data/keying pin |
| cfg_mode | input | 1 | High while a serial configuration session is active |
| soft_rst | input | 1 | Single-cycle request to return to sleep |
| stop_sel | input | 4 | Stop-time select (range bit and step index) |
| state | output | 2 | Current state code |
| xo_en | output | 1 | Crystal oscillator enable |
| synth_en | output | 1 | Frequency synthesizer enable |
| pa_en | output | 1 | Power-amplifier enable |

## Verification
The wake path is driven three ways: a clean rising edge, an edge while configuration mode is held, and a pin that is already high when configuration mode drops. These separate true edge detection from level sensing. The stop timeout is timed with two fine and two coarse selections, which exposes errors in the range bit, the step offset and the ×10 scaling. A low run broken by one high cycle shows whether the count restarts. Soft-reset pulses are applied in start-up, tune and transmit, and each is checked for an immediate return to sleep. A per-cycle scoreboard compares all four outputs against a model built from these rules.

// File: rtl/rf_tx_pkg.sv
package rf_tx_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_XO    = 2'd1,
    ST_TUNE  = 2'd2,
    ST_TX    = 2'd3
  } rf_state_e;

  // Stop time in millisecond units from the 4-bit select
  function automatic logic [31:0] stop_units(input logic [3:0] sel);
    logic [31:0] base;
    base = 32'(sel[2:0]) + 32'd2;
    return sel[3] ? base * 32'd10 : base;
  endfunction

  // Stop time in clock cycles
  function automatic logic [31:0] stop_cycles(input logic [3:0] sel,
                                              input logic [31:0] per_ms);
    return stop_units(sel) * per_ms;
  endfunction

endpackage

// File: rtl/rf_tx_sync.sv
module rf_tx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pin_s,
  output logic pin_rise
);
  logic [STAGES-1:0] chain;
  logic              pin_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_d <= 1'b0;
    else        pin_d <= chain[STAGES-1];
  end

  assign pin_s    = chain[STAGES-1];
  assign pin_rise = pin_s & ~pin_d;

  // A rise event can never repeat on consecutive cycles (R3)
  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise);

endmodule

// File: rtl/rf_tx_timer.sv
module rf_tx_timer
  import rf_tx_pkg::*;
#(
  parameter int unsigned XO_CYCLES   = 12800,
  parameter int unsigned TUNE_CYCLES = 11840,
  parameter int unsigned CYC_PER_MS  = 32000,
  localparam int unsigned PH_MAX     = (XO_CYCLES > TUNE_CYCLES) ? XO_CYCLES : TUNE_CYCLES,
  localparam int unsigned PH_W       = $clog2(PH_MAX + 1),
  localparam int unsigned LOW_W      = $clog2(90 * CYC_PER_MS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  rf_state_e  st,
  input  logic       st_move,
  input  logic       pin_s,
  input  logic [3:0] stop_sel,
  output logic       xo_done,
  output logic       tune_done,
  output logic       stop_hit
);
  logic [PH_W-1:0]  phase;
  logic [LOW_W-1:0] low_cnt;
  logic [LOW_W-1:0] stop_cyc;
  logic             low_run;

  assign stop_cyc = LOW_W'(stop_cycles(stop_sel, 32'(CYC_PER_MS)));
  assign low_run  = (st == ST_TX) && !pin_s;

  // Phase counter: counts cycles spent in the start-up and tune states
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                phase <= '0;
    else if (st_move)                          phase <= '0;
    else if (st == ST_XO || st == ST_TUNE)     phase <= phase + 1'b1;
    else                                       phase <= '0;
  end

  // Low-time counter: consecutive low samples in transmit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  low_cnt <= '0;
    else if (st_move || !low_run) low_cnt <= '0;
    else if (low_cnt < stop_cyc)  low_cnt <= low_cnt + 1'b1;
  end

  assign xo_done   = (st == ST_XO)   && (phase == PH_W'(XO_CYCLES - 1));
  assign tune_done = (st == ST_TUNE) && (phase == PH_W'(TUNE_CYCLES - 1));
  assign stop_hit  = low_run && (low_cnt >= stop_cyc);

  assert_phase_xo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XO) |-> (phase < PH_W'(XO_CYCLES)));

  assert_phase_tune_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TUNE) |-> (phase < PH_W'(TUNE_CYCLES)));

  // A high sample in transmit clears the low count (R9)
  assert_low_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_TX) && pin_s) |=> (low_cnt == '0));

endmodule

// File: rtl/rf_tx_fsm.sv
module rf_tx_fsm
  import rf_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_rise,
  input  logic      cfg_mode,
  input  logic      soft_rst,
  input  logic      xo_done,
  input  logic      tune_done,
  input  logic      stop_hit,
  output rf_state_e st,
  output logic      st_move
);
  rf_state_e st_nxt;

  always_comb begin
    st_nxt = st;
    if (soft_rst) begin
      st_nxt = ST_SLEEP;
    end else begin
      case (st)
        ST_SLEEP: if (pin_rise && !cfg_mode) st_nxt = ST_XO;
        ST_XO:    if (xo_done)               st_nxt = ST_TUNE;
        ST_TUNE:  if (tune_done)             st_nxt = ST_TX;
        ST_TX:    if (stop_hit)              st_nxt = ST_SLEEP;
        default:                             st_nxt = ST_SLEEP;
      endcase
    end
  end

  assign st_move = (st_nxt != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_SLEEP;
    else        st <= st_nxt;
  end

  assert_softrst_sleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (st == ST_SLEEP));

  assert_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_SLEEP) && pin_rise && !cfg_mode && !soft_rst) |=> (st == ST_XO));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_SLEEP) && cfg_mode) |=> (st == ST_SLEEP));

  assert_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_TX) && stop_hit) |=> (st == ST_SLEEP));

  assert_legal_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st)) |-> ((st == ST_SLEEP) || (st == rf_state_e'($past(st) + 2'd1))));

endmodule

// File: rtl/rf_tx_seq.sv
module rf_tx_seq
  import rf_tx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned XO_CYCLES   = 12800,
  parameter int unsigned TUNE_CYCLES = 11840,
  parameter int unsigned CYC_PER_MS  = 32000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_pin,
  input  logic       cfg_mode,
  input  logic       soft_rst,
  input  logic [3:0] stop_sel,
  output logic [1:0] state,
  output logic       xo_en,
  output logic       synth_en,
  output logic       pa_en
);
  logic      pin_s, pin_rise;
  logic      xo_done, tune_done, stop_hit;
  logic      st_move;
  rf_state_e st;

  rf_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (tx_pin),
    .pin_s    (pin_s),
    .pin_rise (pin_rise)
  );

  rf_tx_timer #(
    .XO_CYCLES   (XO_CYCLES),
    .TUNE_CYCLES (TUNE_CYCLES),
    .CYC_PER_MS  (CYC_PER_MS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .st_move   (st_move),
    .pin_s     (pin_s),
    .stop_sel  (stop_sel),
    .xo_done   (xo_done),
    .tune_done (tune_done),
    .stop_hit  (stop_hit)
  );

  rf_tx_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_rise  (pin_rise),
    .cfg_mode  (cfg_mode),
    .soft_rst  (soft_rst),
    .xo_done   (xo_done),
    .tune_done (tune_done),
    .stop_hit  (stop_hit),
    .st        (st),
    .st_move   (st_move)
  );

  assign state    = st;
  assign xo_en    = (st != ST_SLEEP);
  assign synth_en = (st == ST_TUNE) || (st == ST_TX);
  assign pa_en    = (st == ST_TX) && pin_s;

  // PA may only rise while the synthesizer is running (R6)
  assert_pa_needs_synth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pa_en |-> (synth_en && xo_en));

endmodule

// File: tb/rf_tx_seq_test.sv
module rf_tx_seq_test;
  localparam int XO = 5;
  localparam int TU = 4;
  localparam int MS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_pin = 1'b0, cfg_mode = 1'b0, soft_rst = 1'b0;
  logic [3:0] stop_sel = 4'd0;
  logic [1:0] state;
  logic xo_en, synth_en, pa_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  rf_tx_seq #(.XO_CYCLES(XO), .TUNE_CYCLES(TU), .CYC_PER_MS(MS)) uut (
    .clk(clk), .rst_n(rst_n), .tx_pin(tx_pin), .cfg_mode(cfg_mode),
    .soft_rst(soft_rst), .stop_sel(stop_sel), .state(state),
    .xo_en(xo_en), .synth_en(synth_en), .pa_en(pa_en));

  // Stop time restated from R8
  function automatic int stop_of(input logic [3:0] sel);
    int ms;
    case (sel[3])
      1'b0:    ms = 2 + int'(sel[2:0]);
      default: ms = 20 + 10 * int'(sel[2:0]);
    endcase
    return ms * MS;
  endfunction

  // Reference model, pushes expected outputs after every edge
  logic [4:0] exp_q[$];
  bit m_s1, m_s2, m_d;
  int m_st, m_rem, m_low;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_d = 0; m_st = 0; m_rem = 0; m_low = 0;
      exp_q.delete();
    end else begin
      bit seen_hi, edge_seen;
      seen_hi = m_s2;
      edge_seen = m_s2 && !m_d;
      m_d = m_s2; m_s2 = m_s1; m_s1 = tx_pin;
      if (soft_rst) m_st = 0;
      else if (m_st == 0) begin
        if (edge_seen && !cfg_mode) begin m_st = 1; m_rem = XO; end
      end else if (m_st == 1) begin
        m_rem--; if (m_rem == 0) begin m_st = 2; m_rem = TU; end
      end else if (m_st == 2) begin
        m_rem--; if (m_rem == 0) begin m_st = 3; m_low = 0; end
      end else begin
        if (seen_hi) m_low = 0;
        else begin m_low++; if (m_low > stop_of(stop_sel)) m_st = 0; end
      end
      exp_q.push_back({2'(m_st), m_st != 0, m_st >= 2, (m_st == 3) && m_s2});
    end
  end

  // Monitor: compare at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0 && !done) begin
      logic [4:0] e, g;
      e = exp_q.pop_front();
      g = {state, xo_en, synth_en, pa_en};
      n_cmp++;
      if (g !== e) begin
        n_bad++;
        $display("FAIL %s scoreboard: got %b expected %b at %0t", cur_req, g, e, $time);
      end
    end
  end

  task automatic chk(input string req, input int got, input int expv);
    n_cmp++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  task automatic drive_pin(input logic v);
    @(negedge clk); #1 tx_pin = v;
  endtask

  // count falling edges until state equals code
  task automatic wait_for(input int code, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (int'(state) != code && n < 2000);
  endtask

  // at a falling edge showing code, count how long it persists
  task automatic dwell(input int code, output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (int'(state) == code && n < 2000) n++; else break;
    end
  endtask

  task automatic to_tx();
    int n;
    drive_pin(0); repeat (3) @(negedge clk);
    #1 tx_pin = 1;
    wait_for(3, n);
  endtask

  task automatic time_stop(input logic [3:0] sel, input string req);
    int n;
    stop_sel = sel;
    to_tx();
    #1 tx_pin = 0;
    n = 0;
    forever begin
      @(negedge clk);
      if (state == 2'd3 && n < 2000) n++; else break;
    end
    chk(req, n, stop_of(sel) + 2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    // R1: reset values
    repeat (3) @(negedge clk);
    chk("R1 state", int'(state), 0);
    chk("R1 enables", int'({xo_en, synth_en, pa_en}), 0);
    #1 rst_n = 1;

    // R3, R4, R5, R2: wake sequence timing
    cur_req = "R3";
    repeat (2) @(negedge clk);
    #1 tx_pin = 1;
    wait_for(1, n);
    chk("R3 wake latency", n, 3);
    chk("R2 xo_en in start-up", int'(xo_en), 1);
    chk("R2 synth_en in start-up", int'(synth_en), 0);
    cur_req = "R4";
    dwell(1, n);
    chk("R4 start-up length", n, XO);
    cur_req = "R5";
    chk("R2 synth_en in tune", int'(synth_en), 1);
    dwell(2, n);
    chk("R5 tune length", n, TU);
    cur_req = "R6";
    chk("R6 pa follows high pin", int'(pa_en), 1);
    drive_pin(0); drive_pin(1); drive_pin(0); drive_pin(0); drive_pin(1);
    repeat (3) @(negedge clk);
    chk("R6 pa after pattern", int'(pa_en), 1);

    // R7, R8: stop timing at fine and coarse settings
    cur_req = "R7";
    #1 tx_pin = 0;
    n = 0;
    forever begin @(negedge clk); if (state == 2'd3 && n < 2000) n++; else break; end
    chk("R7 fine sel 0", n, stop_of(4'h0) + 2);
    chk("R6 pa off in sleep", int'(pa_en), 0);
    cur_req = "R8";
    time_stop(4'h7, "R8 fine sel 7");
    time_stop(4'h8, "R8 coarse sel 8");
    time_stop(4'hF, "R8 coarse sel 15");

    // R9: one high cycle restarts the low count
    cur_req = "R9";
    stop_sel = 4'h0;
    to_tx();
    #1 tx_pin = 0;
    repeat (5) @(negedge clk);
    #1 tx_pin = 1;
    @(negedge clk);
    #1 tx_pin = 0;
    n = 0;
    forever begin @(negedge clk); if (state == 2'd3 && n < 2000) n++; else break; end
    chk("R9 restart", n, stop_of(4'h0) + 2);

    // R10, R12: configuration mode blocks edges
    cur_req = "R10";
    drive_pin(0);
    #1 cfg_mode = 1;
    repeat (3) @(negedge clk);
    #1 tx_pin = 1;
    repeat (8) @(negedge clk);
    chk("R10 edge in config mode", int'(state), 0);
    cur_req = "R12";
    #1 cfg_mode = 0;
    repeat (8) @(negedge clk);
    chk("R12 level without edge", int'(state), 0);
    drive_pin(0); repeat (3) @(negedge clk);
    #1 tx_pin = 1;
    wait_for(1, n);
    chk("R12 fresh edge wakes", n, 3);

    // R11: soft reset from start-up, tune and transmit
    cur_req = "R11";
    #1 soft_rst = 1;
    @(negedge clk);
    chk("R11 from start-up", int'(state), 0);
    #1 soft_rst = 0;
    to_tx();
    #1 soft_rst = 1;
    @(negedge clk);
    chk("R11 from transmit", int'(state), 0);
    chk("R11 pa off", int'(pa_en), 0);
    #1 soft_rst = 0;
    drive_pin(0); repeat (3) @(negedge clk);
    #1 tx_pin = 1;
    wait_for(2, n);
    #1 soft_rst = 1;
    @(negedge clk);
    chk("R11 from tune", int'(state), 0);
    #1 soft_rst = 0;
    repeat (6) @(negedge clk);
    chk("R11 stays asleep with pin high", int'(state), 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule